// File: doc/BRIEF.md
# Multi-Source Reset Sequencer with Cause Register

This block merges five reset requests into one internal system reset. It holds that reset through a fixed start-up delay after the last request goes away. The five requests are:

- a supply-low level from an analog power detector;
- a supply-sag level from a brown-out detector, gated by an enable input;
- an active-low external reset pin;
- a one-cycle pulse from a watchdog timer;
- a reset level from a debug port.

The system reset asserts in the same cycle that any qualified request is present. It releases only after a quiet period of `TIMEOUT_CYC` cycles has run to completion. A new request during the quiet period aborts it, and a later quiet period starts again from zero.

The pin and the brown-out level pass through glitch qualifiers first. The pin is synchronised through two flops and must stay low for `EXT_MIN_LOW` cycles before it counts. The brown-out level must stay present for `BOD_FILT_CYC` cycles before it counts.

An 8-bit cause register records which requests fired. Software reads it at any time and clears individual flags by writing zeros. The supply-low input resets the whole block asynchronously. It does not clear the supply-low flag: that flag is set by a supply-low event and is cleared only by software.

The sequencer is a three-state machine:

| State | Meaning | Transitions |
|---|---|---|
| `ST_HOLD` | a request is present | goes to `ST_COUNT` when no request is present |
| `ST_COUNT` | quiet period counting | goes back to `ST_HOLD` on any request; goes to `ST_RUN` after `TIMEOUT_CYC` cycles |
| `ST_RUN` | system released | goes to `ST_HOLD` on any request |

The supply-low input forces the machine into `ST_HOLD` asynchronously.

Top module: `rstc_top`

## Requirements
- R1: While `por_i` is high, `sys_rst_o` is high in the same cycle. `por_i` high also resets the cause register to flags `5'b00001` and configuration bits `00`.
- R2: `sys_rst_o` stays high for exactly `TIMEOUT_CYC+1` cycles after the last cycle in which any qualified request was present, and is low in the cycle after that.
- R3: A qualified request that appears while the quiet period is counting aborts the count. The next quiet period is again the full `TIMEOUT_CYC+1` cycles.
- R4: A low level on `ext_rst_n_i` lasting fewer than `EXT_MIN_LOW` consecutive cycles is ignored. A longer low level raises `sys_rst_o` `EXT_MIN_LOW+1` cycles after its first low cycle, and keeps it raised until 2 cycles after the pin returns high.
- R5: With `bod_en_i` high, `bod_i` high for fewer than `BOD_FILT_CYC` consecutive cycles is ignored. `sys_rst_o` rises in the `BOD_FILT_CYC`-th consecutive cycle and stays high while `bod_i` stays high.
- R6: With `bod_en_i` low, `bod_i` has no effect on `sys_rst_o` or on the brown-out flag.
- R7: A one-cycle `wdt_pulse_i` raises `sys_rst_o` in that cycle. The quiet period begins in the next cycle.
- R8: `dbg_rst_i` is a level request that raises `sys_rst_o` in every cycle in which it is high.
- R9: The layout of `reg_rdata_o` is as follows:
  - bits [7:6] are read/write configuration bits;
  - bit 5 reads 0;
  - bit 4 is the debug flag, bit 3 the watchdog flag, bit 2 the brown-out flag, bit 1 the external flag and bit 0 the supply-low flag.
  
  A flag reads 1 from the cycle after its qualified request was present.
- R10: A write (`reg_wr_i` high) clears each flag written 0 and leaves each flag written 1 unchanged. It loads bits [7:6] from `reg_wdata_i[7:6]`. A flag set in the same cycle as a clearing write stays 1.
- R11: The supply-low flag is cleared only by a software write of 0. `por_i` clears the debug, watchdog, brown-out and external flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Supply-low level from the power detector, active high; asynchronous reset of the block |
| bod_en_i | input | 1 | Brown-out request enable |
| bod_i | input | 1 | Supply-sag level from the brown-out detector, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous to `clk` |
| wdt_pulse_i | input | 1 | Watchdog expiry pulse, one cycle |
| dbg_rst_i | input | 1 | Debug-port reset level, active high |
| reg_wr_i | input | 1 | Write strobe for the cause register |
| reg_wdata_i | input | 8 | Write data for the cause register |
| reg_rdata_o | output | 8 | Cause register contents |
| sys_rst_o | output | 1 | Internal system reset, active high |

## Verification
Directed patterns come first. They check that an external low one cycle shorter than the minimum is rejected while one of full length is accepted with the stated latency. They check that a brown-out sag one cycle short is told apart from one that meets the filter, and that a long sag with the enable low has no effect. A watchdog pulse and debug requests injected in the middle of a quiet period separate a counter that restarts from one that pauses. Clearing writes that coincide with a watchdog pulse show whether set wins over clear. A long seeded random mix then overlaps all five requests and register writes. Every cycle it compares the reset output and the register against a bench model built from the stated latencies.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } rstc_state_e;

    localparam int FLG_POR   = 0;
    localparam int FLG_EXT   = 1;
    localparam int FLG_BOD   = 2;
    localparam int FLG_WDT   = 3;
    localparam int FLG_DBG   = 4;
    localparam int NUM_FLAGS = 5;

endpackage

// File: rtl/rstc_qual_filter.sv
// Qualifies an active-high request: optional synchroniser, then a
// minimum run length of consecutive active cycles.
module rstc_qual_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_CYC     = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic req_i,
    output logic qual_o
);

    localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
    localparam logic [CW-1:0] LIM = CW'(MIN_CYC - 1);

    logic          act;
    logic [CW-1:0] run_q;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or posedge por_i) begin
                if (por_i) begin
                    sync_q <= '0;
                end else begin
                    sync_q[0] <= req_i;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end
            assign act = sync_q[SYNC_STAGES-1];
        end else begin : g_nosync
            assign act = req_i;
        end
    endgenerate

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            run_q <= '0;
        end else if (!act) begin
            run_q <= '0;
        end else if (run_q != LIM) begin
            run_q <= run_q + 1'b1;
        end
    end

    assign qual_o = act && (run_q == LIM);

endmodule

// File: rtl/rstc_cause_reg.sv
// Reset cause register: sticky flags, write-zero-to-clear, set wins.
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic                 clk,
    input  logic                 por_i,
    input  logic                 wr_i,
    input  logic [7:0]           wdata_i,
    input  logic [NUM_FLAGS-1:0] set_i,
    output logic [7:0]           rdata_o
);

    logic [NUM_FLAGS-1:0] flags_q;
    logic [1:0]           cfg_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            flags_q <= NUM_FLAGS'(1) << FLG_POR;
            cfg_q   <= '0;
        end else if (wr_i) begin
            flags_q <= (flags_q & wdata_i[NUM_FLAGS-1:0]) | set_i;
            cfg_q   <= wdata_i[7:6];
        end else begin
            flags_q <= flags_q | set_i;
        end
    end

    assign rdata_o = {cfg_q, 1'b0, flags_q};

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int TIMEOUT_CYC  = 64,
    parameter int BOD_FILT_CYC = 8,
    parameter int EXT_MIN_LOW  = 4
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       bod_en_i,
    input  logic       bod_i,
    input  logic       ext_rst_n_i,
    input  logic       wdt_pulse_i,
    input  logic       dbg_rst_i,
    input  logic       reg_wr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       sys_rst_o
);

    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

    logic          ext_q;
    logic          bod_q;
    logic          src_any;
    rstc_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q;

    rstc_qual_filter #(
        .SYNC_STAGES (2),
        .MIN_CYC     (EXT_MIN_LOW)
    ) u_ext_filt (
        .clk    (clk),
        .por_i  (por_i),
        .req_i  (~ext_rst_n_i),
        .qual_o (ext_q)
    );

    rstc_qual_filter #(
        .SYNC_STAGES (0),
        .MIN_CYC     (BOD_FILT_CYC)
    ) u_bod_filt (
        .clk    (clk),
        .por_i  (por_i),
        .req_i  (bod_en_i & bod_i),
        .qual_o (bod_q)
    );

    assign src_any = por_i | ext_q | bod_q | wdt_pulse_i | dbg_rst_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!src_any) state_d = ST_COUNT;
            ST_COUNT: begin
                if (src_any)                state_d = ST_HOLD;
                else if (cnt_q == CNT_LAST) state_d = ST_RUN;
            end
            ST_RUN:   if (src_any) state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    // state register and quiet-period counter
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_COUNT && !src_any) cnt_q <= cnt_q + 1'b1;
            else                                 cnt_q <= '0;
        end
    end

    // outputs
    always_comb begin
        sys_rst_o = src_any | (state_q != ST_RUN);
    end

    rstc_cause_reg u_cause (
        .clk     (clk),
        .por_i   (por_i),
        .wr_i    (reg_wr_i),
        .wdata_i (reg_wdata_i),
        .set_i   ({dbg_rst_i, wdt_pulse_i, bod_q, ext_q, por_i}),
        .rdata_o (reg_rdata_o)
    );

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int TIMEOUT_CYC = 64
) (
    input logic       clk,
    input logic       por_i,
    input logic       wdt_pulse_i,
    input logic       dbg_rst_i,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       sys_rst_o,
    input logic       src_any
);

    localparam int QMAX = TIMEOUT_CYC + 4;

    int unsigned quiet_q;

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)                 quiet_q <= 0;
        else if (src_any)          quiet_q <= 0;
        else if (quiet_q < QMAX)   quiet_q <= quiet_q + 1;
    end

    // R1: supply-low forces reset
    always @(negedge clk) begin
        if (por_i) begin
            a_r1_por_forces_rst: assert (sys_rst_o);
        end
    end

    // R2: release only after the full quiet period
    a_r2_release_window: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> (quiet_q == TIMEOUT_CYC + 1));

    // R7: watchdog pulse resets at once and sets its flag
    a_r7_wdt_rst: assert property (@(posedge clk) disable iff (por_i)
        wdt_pulse_i |-> sys_rst_o);
    a_r7_wdt_flag: assert property (@(posedge clk) disable iff (por_i)
        wdt_pulse_i |=> reg_rdata_o[3]);

    // R8: debug level resets at once
    a_r8_dbg_rst: assert property (@(posedge clk) disable iff (por_i)
        dbg_rst_i |-> sys_rst_o);

    // R9: reserved bit
    a_r9_bit5_zero: assert property (@(posedge clk) disable iff (por_i)
        reg_rdata_o[5] == 1'b0);

    // R11: supply-low flag falls only through a clearing write
    a_r11_porf_sticky: assert property (@(posedge clk) disable iff (por_i)
        $fell(reg_rdata_o[0]) |-> $past(reg_wr_i && !reg_wdata_i[0]));

endmodule

bind rstc_top rstc_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rstc_checker (
    .clk         (clk),
    .por_i       (por_i),
    .wdt_pulse_i (wdt_pulse_i),
    .dbg_rst_i   (dbg_rst_i),
    .reg_wr_i    (reg_wr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .sys_rst_o   (sys_rst_o),
    .src_any     (src_any)
);

// File: tb/test_rstc_top.sv
module test_rstc_top;

    localparam int T = 20;
    localparam int B = 6;
    localparam int E = 3;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       bod_en = 1'b0;
    logic       bod = 1'b0;
    logic       ext_n = 1'b1;
    logic       wdt = 1'b0;
    logic       dbg = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sys_rst;

    int checks = 0;
    int errors = 0;
    string cur_req = "R2";

    // bench model state
    logic       m_p1 = 1'b0, m_p2 = 1'b0;
    int         m_ecnt = 0, m_bcnt = 0, m_quiet = 0;
    logic [4:0] m_flags = 5'b00001;
    logic [1:0] m_cfg = 2'b00;
    logic       last_rst;
    logic [7:0] last_rdata;

    always #5 clk = ~clk;

    rstc_top #(
        .TIMEOUT_CYC  (T),
        .BOD_FILT_CYC (B),
        .EXT_MIN_LOW  (E)
    ) i_rstc_top (
        .clk         (clk),
        .por_i       (por),
        .bod_en_i    (bod_en),
        .bod_i       (bod),
        .ext_rst_n_i (ext_n),
        .wdt_pulse_i (wdt),
        .dbg_rst_i   (dbg),
        .reg_wr_i    (wr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .sys_rst_o   (sys_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat_inc(input int v, input int lim);
        return (v < lim) ? v + 1 : lim;
    endfunction

    // one clock cycle: sample before posedge, advance the model, return at negedge
    task automatic step();
        logic ext_q, bod_q, src;
        int   quiet;
        #4;
        if (por) begin
            m_p1 = 0; m_p2 = 0; m_ecnt = 0; m_bcnt = 0;
            m_flags = 5'b00001; m_cfg = 2'b00;
        end
        ext_q = m_p2 && (m_ecnt >= E - 1);
        bod_q = (bod_en && bod) && (m_bcnt >= B - 1);
        src   = por | ext_q | bod_q | wdt | dbg;
        quiet = src ? 0 : sat_inc(m_quiet, 1000);
        last_rst   = sys_rst;
        last_rdata = rdata;
        check(cur_req, int'(sys_rst), int'(quiet <= T + 1));
        check("R9", int'(rdata), int'({m_cfg, 1'b0, m_flags}));
        m_ecnt  = m_p2 ? sat_inc(m_ecnt, E - 1) : 0;
        m_bcnt  = (bod_en && bod) ? sat_inc(m_bcnt, B - 1) : 0;
        m_p2    = m_p1;
        m_p1    = !ext_n;
        m_quiet = quiet;
        if (por) begin
            m_p1 = 0; m_p2 = 0; m_ecnt = 0; m_bcnt = 0;
            m_flags = 5'b00001; m_cfg = 2'b00;
        end else if (wr) begin
            m_flags = (m_flags & wdata[4:0]) | {dbg, wdt, bod_q, ext_q, 1'b0};
            m_cfg   = wdata[7:6];
        end else begin
            m_flags = m_flags | {dbg, wdt, bod_q, ext_q, 1'b0};
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr = 1'b1; wdata = d;
        step();
        wr = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic seen;
        int   ext_left, bod_left, dbg_left, por_left;
        void'($urandom(32'h5eed_2024));
        @(negedge clk);

        // R1: supply-low held
        cur_req = "R1";
        idle(5);
        check("R1", int'(last_rst), 1);
        check("R1", int'(last_rdata), 8'h01);

        // R2: release timing after supply-low
        por = 1'b0;
        cur_req = "R2";
        for (int i = 0; i < T + 1; i++) begin
            step();
            check("R2", int'(last_rst), 1);
        end
        step();
        check("R2", int'(last_rst), 0);
        idle(2);

        // R4: short pin low rejected
        cur_req = "R4";
        seen = 1'b0;
        ext_n = 1'b0;
        for (int i = 0; i < E - 1; i++) begin step(); seen |= last_rst; end
        ext_n = 1'b1;
        for (int i = 0; i < 5; i++) begin step(); seen |= last_rst; end
        check("R4", int'(seen), 0);
        check("R4", int'(last_rdata[1]), 0);
        // R4: full-length low accepted with latency E+1
        ext_n = 1'b0;
        for (int i = 0; i < E + 1; i++) begin
            step();
            check("R4", int'(last_rst), 0);
        end
        step();
        check("R4", int'(last_rst), 1);
        step();
        check("R4", int'(last_rdata[1]), 1);
        ext_n = 1'b1;
        idle(T + 6);
        check("R2", int'(last_rst), 0);

        // R5: brown-out filter
        cur_req = "R5";
        bod_en = 1'b1;
        seen = 1'b0;
        bod = 1'b1;
        for (int i = 0; i < B - 1; i++) begin step(); seen |= last_rst; end
        bod = 1'b0;
        step(); seen |= last_rst;
        check("R5", int'(seen), 0);
        bod = 1'b1;
        for (int i = 0; i < B - 1; i++) step();
        check("R5", int'(last_rst), 0);
        step();
        check("R5", int'(last_rst), 1);
        step();
        check("R5", int'(last_rdata[2]), 1);
        bod = 1'b0;
        idle(T + 4);

        // R6: brown-out ignored when disabled
        cur_req = "R6";
        write_reg(8'h01);
        bod_en = 1'b0;
        bod = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 3 * B; i++) begin step(); seen |= last_rst; end
        check("R6", int'(seen), 0);
        check("R6", int'(last_rdata[2]), 0);
        bod = 1'b0;
        idle(2);

        // R7: watchdog pulse, quiet period from next cycle
        cur_req = "R7";
        wdt = 1'b1;
        step();
        check("R7", int'(last_rst), 1);
        wdt = 1'b0;
        for (int i = 0; i < T + 1; i++) begin
            step();
            check("R7", int'(last_rst), 1);
        end
        step();
        check("R7", int'(last_rst), 0);
        check("R7", int'(last_rdata[3]), 1);

        // R8 and R3: debug request, then abort of a running quiet period
        cur_req = "R8";
        dbg = 1'b1;
        idle(3);
        check("R8", int'(last_rst), 1);
        dbg = 1'b0;
        cur_req = "R3";
        idle(6);
        dbg = 1'b1;
        step();
        check("R8", int'(last_rst), 1);
        dbg = 1'b0;
        for (int i = 0; i < T + 1; i++) begin
            step();
            check("R3", int'(last_rst), 1);
        end
        step();
        check("R3", int'(last_rst), 0);
        check("R8", int'(last_rdata[4]), 1);

        // R10: write-one keeps, write-zero clears, set wins
        cur_req = "R10";
        write_reg(8'hFF);
        step();
        check("R10", int'(last_rdata[7:3]), 5'b11011);
        wdt = 1'b1; wr = 1'b1; wdata = 8'h01;
        step();
        wdt = 1'b0; wr = 1'b0;
        step();
        check("R10", int'(last_rdata[3]), 1);
        check("R10", int'(last_rdata[7:6]), 0);
        check("R10", int'(last_rdata[4]), 0);
        idle(T + 3);

        // R11: supply-low flag sticky through other resets, cleared by software
        cur_req = "R11";
        write_reg(8'hC0);
        step();
        check("R11", int'(last_rdata), 8'hC0);
        dbg = 1'b1; step(); dbg = 1'b0;
        step();
        check("R11", int'(last_rdata[0]), 0);
        por = 1'b1;
        step();
        check("R11", int'(last_rdata), 8'h01);
        por = 1'b0;
        idle(T + 3);

        // constrained random mix
        cur_req = "R2";
        ext_left = 0; bod_left = 0; dbg_left = 0; por_left = 0;
        for (int c = 0; c < 4000; c++) begin
            if (ext_left == 0) begin
                ext_n    = ($urandom % 5 == 0) ? 1'b0 : 1'b1;
                ext_left = 1 + $urandom % (2 * E + 2);
            end
            ext_left--;
            if (bod_left == 0) begin
                bod      = ($urandom % 6 == 0);
                bod_left = 1 + $urandom % (2 * B);
            end
            bod_left--;
            if (c % 300 == 0) bod_en = $urandom % 2;
            if (dbg_left == 0) begin
                dbg      = ($urandom % 40 == 0);
                dbg_left = 1 + $urandom % 4;
            end
            dbg_left--;
            if (por_left > 0) por_left--;
            else if ($urandom % 500 == 0) por_left = 1 + $urandom % 3;
            por   = (por_left > 0);
            wdt   = ($urandom % 60 == 0);
            wr    = ($urandom % 8 == 0);
            wdata = 8'($urandom);
            step();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule